// File: doc/BRIEF.md
# Instruction Queue with Out-of-Order Branch Removal

This block sits between instruction fetch and the issue stage of a pipelined core. Fetched instruction words arrive on a ready/valid push port. Each word carries one tag bit that marks it as a branch or a non-branch, and every word is stored in the queue before it can leave. Non-branch words leave strictly in program order, through an issue port that only ever shows the entry at the head of the queue. Branch words leave through a separate dispatch port, and they may do so from any slot, ahead of older non-branch words that are still waiting. This lets the branch unit work on a branch while the instructions before it are still queued.

When more than one branch is held, the oldest branch is offered first. Entries can leave from the middle of the queue, and the entries that remain close the gap in the same cycle without changing their relative order. In one cycle a branch and the head non-branch may both leave, and a new word may also be pushed.

A single flush input empties the whole queue. The surrounding core raises it on an exception, an interrupt, a mispredicted fetch or a recovery of the history buffer. A flush takes priority over a push made in the same cycle.

Top module: `inst_queue_fold`

## Requirements
- R1: After a synchronous reset the queue is empty: `iss_valid` and `br_valid` are 0 and `in_ready` is 1.
- R2: `in_ready` is 1 exactly when fewer than DEPTH entries (default 4) are held. A word is stored when `in_valid` and `in_ready` are both 1, and a word offered while `in_ready` is 0 is not stored.
- R3: `iss_valid` is 1 only when the head entry exists, has tag `in_is_br`=0, and no flush is asserted. `iss_word` is then the head word.
- R4: `br_valid` is 1 whenever any held entry has tag 1 (branch) and no flush is asserted. `br_word` is the oldest such entry, even when older non-branch entries are still held.
- R5: After any entry is removed, the remaining entries keep their program order and the gap is closed in that same cycle. A newly pushed word is appended after all of them.
- R6: A branch dispatch and a head issue may both complete in the same cycle, and each one removes exactly its own entry.
- R7: While `flush` is 1, `iss_valid` and `br_valid` are 0. In the cycle after a flush the queue is empty.
- R8: A word pushed in the same cycle as a flush is discarded and never appears on either output port.
- R9: While an offered word is not taken (its ready is 0) and no flush occurs, the same word stays offered in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the queue; pushes in the same cycle are dropped |
| in_valid | input | 1 | Fetch offers a word |
| in_ready | output | 1 | Queue has a free slot |
| in_word | input | WORD_W | Fetched instruction word |
| in_is_br | input | 1 | 1 = branch, 0 = non-branch |
| iss_valid | output | 1 | Head non-branch is offered for issue |
| iss_ready | input | 1 | Execution side accepts the head word |
| iss_word | output | WORD_W | Head non-branch word |
| br_valid | output | 1 | Oldest branch is offered to the branch unit |
| br_ready | input | 1 | Branch unit accepts the offered branch |
| br_word | output | WORD_W | Oldest held branch word |

## Verification
If the compaction is wrong, a word is lost, duplicated or reordered. This shows at the issue or branch port the next time that slot reaches the head or becomes the oldest branch, which is usually within a few cycles. A stale occupancy count shows at once as a wrong `in_ready`, or as a valid that is raised over an empty slot. A flush that fails to clear the queue shows in the following cycle as a valid that should not be there. The bench compares every port against a reference queue on every cycle, so each of these faults is reported in the cycle it first becomes visible.

// File: rtl/iq_pkg.sv
package iq_pkg;
  // How entries leave the queue in a given cycle
  typedef enum logic [1:0] {
    POP_NONE   = 2'b00,
    POP_ISSUE  = 2'b01,
    POP_BRANCH = 2'b10,
    POP_BOTH   = 2'b11
  } pop_kind_e;

  localparam int IQ_DEPTH_DEFAULT = 4;
  localparam int IQ_WORD_DEFAULT  = 32;
endpackage

// File: rtl/iq_branch_pick.sv
module iq_branch_pick #(
  parameter int DEPTH = 4,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] cand,
  output logic             found,
  output logic [IW-1:0]    idx,
  output logic [DEPTH-1:0] onehot
);
  // Lowest index is the oldest entry; scan downward so it wins.
  always_comb begin
    found  = 1'b0;
    idx    = '0;
    onehot = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found  = 1'b1;
        idx    = IW'(i);
        onehot = '0;
        onehot[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/iq_compact.sv
module iq_compact #(
  parameter int DEPTH  = 4,
  parameter int WORD_W = 32,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0][WORD_W-1:0] cur_word,
  input  logic [DEPTH-1:0]             cur_br,
  input  logic [CW-1:0]                cur_cnt,
  input  logic [DEPTH-1:0]             remove,
  input  logic                         push,
  input  logic [WORD_W-1:0]            push_word,
  input  logic                         push_br,
  output logic [DEPTH-1:0][WORD_W-1:0] nxt_word,
  output logic [DEPTH-1:0]             nxt_br,
  output logic [CW-1:0]                nxt_cnt
);
  logic [CW-1:0] kept;

  // Survivors slide down in order, then the pushed word goes at the tail.
  always_comb begin
    kept     = '0;
    nxt_word = cur_word;
    nxt_br   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CW'(i) < cur_cnt) && !remove[i]) begin
        nxt_word[kept[IW-1:0]] = cur_word[i];
        nxt_br[kept[IW-1:0]]   = cur_br[i];
        kept = kept + 1'b1;
      end
    end
    if (push && (kept < CW'(DEPTH))) begin
      nxt_word[kept[IW-1:0]] = push_word;
      nxt_br[kept[IW-1:0]]   = push_br;
      kept = kept + 1'b1;
    end
    nxt_cnt = kept;
  end
endmodule

// File: rtl/inst_queue_fold.sv
module inst_queue_fold
  import iq_pkg::*;
#(
  parameter int DEPTH  = IQ_DEPTH_DEFAULT,
  parameter int WORD_W = IQ_WORD_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_is_br,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [WORD_W-1:0] iss_word,
  output logic              br_valid,
  input  logic              br_ready,
  output logic [WORD_W-1:0] br_word
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0][WORD_W-1:0] q_word, nx_word;
  logic [DEPTH-1:0]             q_br, nx_br;
  logic [CW-1:0]                q_cnt, nx_cnt;

  logic [DEPTH-1:0] occupied, br_cand, br_onehot, remove;
  logic             br_found, iss_fire, br_fire, push;
  logic [IW-1:0]    br_idx;
  pop_kind_e        pop_kind;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      assign occupied[g] = CW'(g) < q_cnt;
      assign br_cand[g]  = occupied[g] & q_br[g];
    end
  endgenerate

  iq_branch_pick #(.DEPTH(DEPTH)) u_pick (
    .cand   (br_cand),
    .found  (br_found),
    .idx    (br_idx),
    .onehot (br_onehot)
  );

  assign in_ready  = q_cnt < CW'(DEPTH);
  assign iss_valid = !flush && occupied[0] && !q_br[0];
  assign iss_word  = q_word[0];
  assign br_valid  = !flush && br_found;
  assign br_word   = q_word[br_idx];

  assign iss_fire = iss_valid && iss_ready;
  assign br_fire  = br_valid && br_ready;
  assign push     = in_valid && in_ready && !flush;
  assign pop_kind = pop_kind_e'({br_fire, iss_fire});

  always_comb begin
    remove = '0;
    unique case (pop_kind)
      POP_ISSUE:  remove[0] = 1'b1;
      POP_BRANCH: remove    = br_onehot;
      POP_BOTH:   begin remove = br_onehot; remove[0] = 1'b1; end
      default:    remove = '0;
    endcase
  end

  iq_compact #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_compact (
    .cur_word  (q_word),
    .cur_br    (q_br),
    .cur_cnt   (q_cnt),
    .remove    (remove),
    .push      (push),
    .push_word (in_word),
    .push_br   (in_is_br),
    .nxt_word  (nx_word),
    .nxt_br    (nx_br),
    .nxt_cnt   (nx_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      q_cnt <= '0;
      q_br  <= '0;
    end else begin
      q_cnt <= nx_cnt;
      q_br  <= nx_br;
    end
    q_word <= nx_word;
  end

  // R2: occupancy never exceeds capacity
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    q_cnt <= CW'(DEPTH));

  // R7: a flush leaves an empty queue behind it
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (rst)
    flush |=> (q_cnt == '0) && !iss_valid && !br_valid);

  // R9: an unaccepted head word stays in place
  p_hold_head_r9: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_ready) |=> flush || (iss_valid && iss_word == $past(iss_word)));

  // R6: head and branch never name the same slot for removal
  p_disjoint_pop_r6: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> !br_onehot[0]);

  // R4: the branch picker selects at most one slot
  p_pick_single_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(br_onehot));

  // R5: each cycle count moves by pushes minus removals
  p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
    !flush |=> q_cnt == $past(q_cnt) + CW'($past(push)) - CW'($countones($past(remove))));
endmodule

// File: tb/sim_inst_queue_fold.sv
module sim_inst_queue_fold;
  localparam int PER = 10;
  localparam int D   = 4;
  localparam int W   = 32;

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
  logic in_valid = 1'b0, in_is_br = 1'b0, iss_ready = 1'b0, br_ready = 1'b0;
  logic [W-1:0] in_word = '0;
  logic in_ready, iss_valid, br_valid;
  logic [W-1:0] iss_word, br_word;

  int total = 0, bad = 0;
  logic [W-1:0] m_w [D];
  logic         m_b [D];
  int           m_n = 0;

  always #(PER/2) clk = ~clk;

  inst_queue_fold #(.DEPTH(D), .WORD_W(W)) u0 (
    .clk(clk), .rst(rst), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_is_br(in_is_br),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_word(iss_word),
    .br_valid(br_valid), .br_ready(br_ready), .br_word(br_word)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit e_ready();
    return m_n < D;
  endfunction
  function automatic bit e_iss();
    return !flush && m_n > 0 && !m_b[0];
  endfunction
  function automatic int e_bidx();
    for (int i = 0; i < D; i++) if (i < m_n && m_b[i]) return i;
    return -1;
  endfunction

  task automatic drive(input bit v, input bit b, input logic [W-1:0] wd,
                       input bit ir, input bit brr, input bit fl);
    @(negedge clk);
    in_valid = v; in_is_br = b; in_word = wd;
    iss_ready = ir; br_ready = brr; flush = fl;
    #1;
  endtask

  task automatic commit();
    int bi;
    bit ie, be;
    logic [W-1:0] nw [D];
    logic         nb [D];
    int k;
    bi = e_bidx();
    ie = e_iss();
    be = !flush && bi >= 0;
    chk(in_ready == e_ready(), "R2 in_ready", W'(in_ready), W'(e_ready()));
    chk(iss_valid == ie, "R3 iss_valid", W'(iss_valid), W'(ie));
    if (ie) chk(iss_word == m_w[0], "R3 iss_word", iss_word, m_w[0]);
    chk(br_valid == be, "R4 br_valid", W'(br_valid), W'(be));
    if (be) chk(br_word == m_w[bi], "R4 br_word", br_word, m_w[bi]);
    if (flush) begin
      m_n = 0;
    end else begin
      k = 0;
      for (int i = 0; i < m_n; i++) begin
        if (!((i == 0 && ie && iss_ready) || (be && br_ready && i == bi))) begin
          nw[k] = m_w[i]; nb[k] = m_b[i]; k++;
        end
      end
      if (in_valid && m_n < D) begin nw[k] = in_word; nb[k] = in_is_br; k++; end
      for (int i = 0; i < k; i++) begin m_w[i] = nw[i]; m_b[i] = nb[i]; end
      m_n = k;
    end
    @(posedge clk);
  endtask

  initial begin
    #(PER * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: empty after reset
    drive(0, 0, '0, 0, 0, 0);
    chk(in_ready == 1'b1, "R1 in_ready", W'(in_ready), 1);
    chk(!iss_valid && !br_valid, "R1 valids", W'({iss_valid, br_valid}), 0);
    commit();

    // Fill with N A, N B, branch C, N D
    drive(1, 0, 32'hA, 0, 0, 0); commit();
    drive(1, 0, 32'hB, 0, 0, 0); commit();
    drive(1, 1, 32'hC, 0, 0, 0); commit();
    drive(1, 0, 32'hD, 0, 0, 0); commit();
    // R2: full queue refuses E
    drive(1, 0, 32'hE, 0, 0, 0);
    chk(in_ready == 1'b0, "R2 full", W'(in_ready), 0);
    commit();
    // R4: branch C leaves ahead of older A and B
    drive(0, 0, '0, 0, 1, 0);
    chk(br_valid && br_word == 32'hC, "R4 oldest branch ahead", br_word, 32'hC);
    commit();
    // R5: remaining order A, B, D; E never stored (R2)
    drive(0, 0, '0, 1, 0, 0);
    chk(iss_word == 32'hA, "R5 order first", iss_word, 32'hA); commit();
    drive(0, 0, '0, 1, 0, 0);
    chk(iss_word == 32'hB, "R5 order second", iss_word, 32'hB); commit();
    drive(0, 0, '0, 1, 0, 0);
    chk(iss_word == 32'hD, "R5 order third", iss_word, 32'hD); commit();
    drive(0, 0, '0, 0, 0, 0);
    chk(!iss_valid && in_ready, "R2 rejected word absent", W'(iss_valid), 0); commit();

    // R9: stalled head holds
    drive(1, 0, 32'h55, 0, 0, 0); commit();
    drive(0, 0, '0, 0, 0, 0);
    chk(iss_word == 32'h55, "R9 hold first", iss_word, 32'h55); commit();
    drive(0, 0, '0, 0, 0, 0);
    chk(iss_valid && iss_word == 32'h55, "R9 hold second", iss_word, 32'h55); commit();

    // R6: head issue and branch dispatch together
    drive(1, 1, 32'h66, 0, 0, 0); commit();
    drive(0, 0, '0, 1, 1, 0);
    chk(iss_valid && br_valid, "R6 both offered", W'({iss_valid, br_valid}), 3); commit();
    drive(0, 0, '0, 0, 0, 0);
    chk(!iss_valid && !br_valid, "R6 both removed", W'({iss_valid, br_valid}), 0); commit();

    // R7 and R8: flush with a simultaneous push
    drive(1, 0, 32'h77, 0, 0, 0); commit();
    drive(1, 1, 32'h88, 1, 1, 1);
    chk(!iss_valid && !br_valid, "R7 quiet during flush", W'({iss_valid, br_valid}), 0); commit();
    drive(0, 0, '0, 1, 1, 0);
    chk(!iss_valid && !br_valid && in_ready, "R8 pushed word discarded", W'({iss_valid, br_valid}), 0);
    commit();

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      drive(($urandom % 4) != 0, ($urandom % 3) == 0, $urandom,
            ($urandom % 3) != 0, ($urandom % 2) == 0, ($urandom % 40) == 0);
      commit();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule